// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading a two-level translation structure out of memory. A request carries the linear address and two attributes: whether the access is a write and whether it comes from user mode. The walker fetches the directory entry from the page directory named by the root frame input. It then either stops there, when the entry maps a 4 MB page, or fetches a page table entry that maps a 4 KB page. It returns either a physical address or a page fault with a status code. The faulting linear address is kept in a register for later inspection.

The walker keeps the usage flags in the tables up to date. Before it moves past an entry whose Accessed flag is clear, it writes that entry back with the flag set. When a write request reaches the final entry, it also sets the Dirty flag in the same write. Only one request is handled at a time. The memory side is a single outstanding request that is held until it is acknowledged.

Top module: `pgwalk`

## Requirements
- R1: The first read of a walk is at address {root_frame, linear[31:22], 2'b00}, and the walker holds each memory request, address and write enable stable until mem_ack.
- R2: For a 4 KB mapping, the second read is at {directory entry[31:12], linear[21:12], 2'b00}.
- R3: A successful 4 KB walk returns rsp_paddr = {table entry[31:12], linear[11:0]}.
- R4: A present directory entry with bit 7 set maps a 4 MB page. No table read is made, and rsp_paddr = {directory entry[31:22], linear[21:0]}.
- R5: An entry with bit 0 (present) clear ends the walk with rsp_fault high and status bit 0 low. The linear address is copied to fault_addr.
- R6: A write request faults if bit 1 (writable) is clear in any entry read. A user request faults if bit 2 (user allowed) is clear in any entry read. Both cases give status bit 0 high.
- R7: Each entry read that has bit 5 (Accessed) clear is written back with bit 5 set before the walk continues. No write is made when nothing would change, and a faulting entry is never written.
- R8: On a write request, the final entry is written with bit 6 (Dirty) set. A directory entry that points to a table never gets bit 6 set.
- R9: rsp_status is {user, write, protection} on a fault and zero on a successful walk.
- R10: req_ready is high only while idle. It falls on acceptance and stays low until the single-cycle rsp_valid pulse.
- R11: fault_addr changes only when a walk faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_frame | input | 20 | Frame number of the page directory |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Request is a write access |
| req_user | input | 1 | Request comes from user mode |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending access is a write-back |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for a write-back |
| mem_ack | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 32 | Entry read, valid with mem_ack |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Walk ended in a page fault |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_status | output | 3 | Fault cause {user, write, protection} |
| fault_addr | output | 32 | Linear address of the latest fault |

## Verification
Two updates can fall into a single memory write: setting Accessed and setting Dirty on the final entry. They combine when a write request reaches a leaf entry that has both flags clear. The bench forces this case with directed entries for both a 4 MB directory leaf and a 4 KB table leaf. It judges the result by reading back the stored word, which must gain both bits. It also counts write transactions, which must be exactly one for that entry. A third directed case uses a non-leaf directory entry under a write and checks that only Accessed is added there. Random tables with random acknowledge delays then mix these with faults and already-set flags.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

   localparam int FLG_PRESENT = 0;
   localparam int FLG_WRITE   = 1;
   localparam int FLG_USER    = 2;
   localparam int FLG_ACCESS  = 5;
   localparam int FLG_DIRTY   = 6;
   localparam int FLG_LARGE   = 7;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_DIR_RD,
      WS_DIR_WB,
      WS_TBL_RD,
      WS_TBL_WB,
      WS_RESP
   } walk_state_e;

endpackage

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
   import pgwalk_pkg::*;
#(
   parameter int ENT_W = 32
) (
   input  logic [ENT_W-1:0] entry,
   input  logic             is_write,
   input  logic             is_user,
   input  logic             at_leaf,
   output logic             deny_np,
   output logic             deny_prot,
   output logic             need_wb,
   output logic [ENT_W-1:0] wb_word
);

   if (ENT_W <= FLG_LARGE) begin : g_bad_width
      $error("pgwalk_perm: ENT_W too small for the flag field");
   end

   logic [ENT_W-1:0] set_mask;

   always_comb begin
      set_mask = '0;
      set_mask[FLG_ACCESS] = 1'b1;
      set_mask[FLG_DIRTY]  = at_leaf & is_write;
   end

   assign deny_np   = ~entry[FLG_PRESENT];
   assign deny_prot = entry[FLG_PRESENT] &
                      ((is_write & ~entry[FLG_WRITE]) | (is_user & ~entry[FLG_USER]));
   assign wb_word   = entry | set_mask;
   assign need_wb   = (wb_word != entry);

endmodule

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
   parameter int LIN_W    = 32,
   parameter int IDX_W    = 10,
   parameter int OFF_W    = 12,
   parameter bit LARGE_EN = 1'b1,
   localparam int FRAME_W = LIN_W - OFF_W,
   localparam int LOFF_W  = IDX_W + OFF_W
) (
   input  logic [FRAME_W-1:0] root_frame,
   input  logic [LIN_W-1:0]   lin,
   input  logic [FRAME_W-1:0] pde_frame,
   input  logic [FRAME_W-1:0] pte_frame,
   input  logic               cand_ps,
   output logic [LIN_W-1:0]   dir_addr,
   output logic [LIN_W-1:0]   tbl_addr,
   output logic [LIN_W-1:0]   pa_small,
   output logic [LIN_W-1:0]   pa_large,
   output logic               cand_large
);

   if (LIN_W != 2 * IDX_W + OFF_W) begin : g_bad_split
      $error("pgwalk_addr: LIN_W must equal 2*IDX_W+OFF_W");
   end
   if (OFF_W != IDX_W + 2) begin : g_bad_table
      $error("pgwalk_addr: a table of 4-byte entries must fill one page");
   end

   assign dir_addr = {root_frame, lin[LIN_W-1 -: IDX_W], 2'b00};
   assign tbl_addr = {pde_frame, lin[OFF_W +: IDX_W], 2'b00};
   assign pa_small = {pte_frame, lin[OFF_W-1:0]};
   assign pa_large = {pde_frame[FRAME_W-1 -: IDX_W], lin[LOFF_W-1:0]};

   if (LARGE_EN) begin : g_large_on
      assign cand_large = cand_ps;
   end else begin : g_large_off
      assign cand_large = cand_ps & 1'b0;
   end

endmodule

// File: rtl/pgwalk.sv
module pgwalk
   import pgwalk_pkg::*;
#(
   parameter int LIN_W    = 32,
   parameter int IDX_W    = 10,
   parameter int OFF_W    = 12,
   parameter bit LARGE_EN = 1'b1,
   localparam int FRAME_W = LIN_W - OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FRAME_W-1:0] root_frame,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [LIN_W-1:0]   req_lin,
   input  logic               req_write,
   input  logic               req_user,
   output logic               mem_req,
   output logic               mem_we,
   output logic [LIN_W-1:0]   mem_addr,
   output logic [LIN_W-1:0]   mem_wdata,
   input  logic               mem_ack,
   input  logic [LIN_W-1:0]   mem_rdata,
   output logic               rsp_valid,
   output logic               rsp_fault,
   output logic [LIN_W-1:0]   rsp_paddr,
   output logic [2:0]         rsp_status,
   output logic [LIN_W-1:0]   fault_addr
);

   walk_state_e      st;
   logic [LIN_W-1:0] lin_q, pde_q, pte_q, flt_q;
   logic             wr_q, usr_q, large_q, fault_q;
   logic [2:0]       stat_q;

   logic [LIN_W-1:0] dir_addr, tbl_addr, pa_small, pa_large, wb_word;
   logic             cand_large, at_leaf, deny_np, deny_prot, need_wb;

   pgwalk_addr #(
      .LIN_W(LIN_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LARGE_EN(LARGE_EN)
   ) i_addr (
      .root_frame (root_frame),
      .lin        (lin_q),
      .pde_frame  (pde_q[LIN_W-1:OFF_W]),
      .pte_frame  (pte_q[LIN_W-1:OFF_W]),
      .cand_ps    (mem_rdata[FLG_LARGE]),
      .dir_addr   (dir_addr),
      .tbl_addr   (tbl_addr),
      .pa_small   (pa_small),
      .pa_large   (pa_large),
      .cand_large (cand_large)
   );

   assign at_leaf = (st == WS_TBL_RD) | cand_large;

   pgwalk_perm #(.ENT_W(LIN_W)) i_perm (
      .entry     (mem_rdata),
      .is_write  (wr_q),
      .is_user   (usr_q),
      .at_leaf   (at_leaf),
      .deny_np   (deny_np),
      .deny_prot (deny_prot),
      .need_wb   (need_wb),
      .wb_word   (wb_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= WS_IDLE;
         lin_q   <= '0;
         pde_q   <= '0;
         pte_q   <= '0;
         flt_q   <= '0;
         wr_q    <= 1'b0;
         usr_q   <= 1'b0;
         large_q <= 1'b0;
         fault_q <= 1'b0;
         stat_q  <= '0;
      end else begin
         unique case (st)
            WS_IDLE: if (req_valid) begin
               lin_q   <= req_lin;
               wr_q    <= req_write;
               usr_q   <= req_user;
               large_q <= 1'b0;
               fault_q <= 1'b0;
               stat_q  <= '0;
               st      <= WS_DIR_RD;
            end
            WS_DIR_RD: if (mem_ack) begin
               pde_q <= wb_word;
               if (deny_np || deny_prot) begin
                  fault_q <= 1'b1;
                  stat_q  <= {usr_q, wr_q, deny_prot};
                  flt_q   <= lin_q;
                  st      <= WS_RESP;
               end else begin
                  large_q <= cand_large;
                  if (need_wb)         st <= WS_DIR_WB;
                  else if (cand_large) st <= WS_RESP;
                  else                 st <= WS_TBL_RD;
               end
            end
            WS_DIR_WB: if (mem_ack) st <= large_q ? WS_RESP : WS_TBL_RD;
            WS_TBL_RD: if (mem_ack) begin
               pte_q <= wb_word;
               if (deny_np || deny_prot) begin
                  fault_q <= 1'b1;
                  stat_q  <= {usr_q, wr_q, deny_prot};
                  flt_q   <= lin_q;
                  st      <= WS_RESP;
               end else begin
                  st <= need_wb ? WS_TBL_WB : WS_RESP;
               end
            end
            WS_TBL_WB: if (mem_ack) st <= WS_RESP;
            WS_RESP:   st <= WS_IDLE;
            default:   st <= WS_IDLE;
         endcase
      end
   end

   assign req_ready  = (st == WS_IDLE);
   assign mem_req    = (st == WS_DIR_RD) | (st == WS_DIR_WB) |
                       (st == WS_TBL_RD) | (st == WS_TBL_WB);
   assign mem_we     = (st == WS_DIR_WB) | (st == WS_TBL_WB);
   assign mem_addr   = ((st == WS_DIR_RD) || (st == WS_DIR_WB)) ? dir_addr : tbl_addr;
   assign mem_wdata  = (st == WS_DIR_WB) ? pde_q : ((st == WS_TBL_WB) ? pte_q : '0);
   assign rsp_valid  = (st == WS_RESP);
   assign rsp_fault  = rsp_valid & fault_q;
   assign rsp_status = rsp_fault ? stat_q : '0;
   assign rsp_paddr  = (rsp_valid && !fault_q) ? (large_q ? pa_large : pa_small) : '0;
   assign fault_addr = flt_q;

   // R10: the response lasts one cycle and acceptance makes the walker busy
   p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   // R1: a pending memory access is held until acknowledged
   p_hold_mem_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
   // R7: every write-back carries the Accessed flag
   p_wb_accessed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[FLG_ACCESS]);
   // R9: a successful walk reports a clear status
   p_ok_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |-> (rsp_status == 3'b000));
   // R11: the fault address is left alone by walks that succeed
   p_fault_addr_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |-> $stable(fault_addr));

endmodule

// File: tb/test_pgwalk.sv
module test_pgwalk;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] root_frame = '0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
   logic [31:0] req_lin = '0;
   logic        req_ready, mem_req, mem_we, rsp_valid, rsp_fault;
   logic [31:0] mem_addr, mem_wdata, rsp_paddr, fault_addr;
   logic [2:0]  rsp_status;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #4 clk = ~clk;

   pgwalk i_pgwalk (
      .clk(clk), .rst_n(rst_n), .root_frame(root_frame),
      .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
      .req_write(req_write), .req_user(req_user),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
      .rsp_status(rsp_status), .fault_addr(fault_addr)
   );

   // memory model: 4 pages, directory in page 0, tables in pages 1..3
   logic [31:0] mem [0:4095];
   logic        ld_en = 1'b0;
   logic [11:0] ld_idx = '0;
   logic [31:0] ld_val = '0;
   int          rd_cnt = 0, wr_cnt = 0;
   logic [31:0] hist0 = '0, hist1 = '0;

   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (ld_en) mem[ld_idx] <= ld_val;
      if (mem_req && !mem_ack && ($urandom % 4) != 0) begin
         mem_ack   <= 1'b1;
         mem_rdata <= mem[mem_addr[13:2]];
         if (mem_we) begin
            mem[mem_addr[13:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            rd_cnt <= rd_cnt + 1;
            hist1  <= hist0;
            hist0  <= mem_addr;
         end
      end
   end

   int          n_chk = 0, n_bad = 0;
   logic [31:0] cr2_model = '0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic load(input logic [11:0] idx, input logic [31:0] val);
      @(negedge clk);
      ld_en = 1'b1; ld_idx = idx; ld_val = val;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   function automatic logic [31:0] rnd_entry(input bit is_dir);
      logic [31:0] r, e;
      r = $urandom;
      e = {20'h0, 3'b000, 1'b0, 2'b00, r[6:5], 2'b00, r[2:1], (r[10:8] != 3'b000)};
      if (is_dir) begin
         if (r[12:11] == 2'b00) e = e | 32'h80 | {r[31:22], 22'h0};
         else e[31:12] = 20'd1 + 20'(r[20:13] % 3);
      end else begin
         e[31:12] = r[31:12];
      end
      return e;
   endfunction

   task automatic walk(input logic [31:0] lin, input bit wr, input bit usr);
      logic [31:0] pde, pte, pde_new, pte_new, daddr, taddr, e_pa;
      bit e_flt, e_prot, big, to;
      int e_rd, e_wr, rd0, wr0, n;
      daddr = {root_frame, lin[31:22], 2'b00};
      pde = mem[daddr[13:2]];
      pte = '0; taddr = '0; pte_new = '0; e_pa = '0;
      e_flt = 0; e_prot = 0; big = 0; e_rd = 1; e_wr = 0; pde_new = pde;
      if (!pde[0]) e_flt = 1;
      else if ((wr && !pde[1]) || (usr && !pde[2])) begin e_flt = 1; e_prot = 1; end
      else if (pde[7]) begin
         big = 1;
         pde_new = pde | 32'h20 | (wr ? 32'h40 : 32'h0);
         e_pa = {pde[31:22], lin[21:0]};
      end else begin
         pde_new = pde | 32'h20;
         taddr = {pde[31:12], lin[21:12], 2'b00};
         pte = mem[taddr[13:2]];
         pte_new = pte;
         e_rd = 2;
         if (!pte[0]) e_flt = 1;
         else if ((wr && !pte[1]) || (usr && !pte[2])) begin e_flt = 1; e_prot = 1; end
         else begin
            pte_new = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
            e_pa = {pte[31:12], lin[11:0]};
         end
      end
      e_wr = int'(pde_new != pde) + int'(pte_new != pte);
      if (e_flt) cr2_model = lin;
      rd0 = rd_cnt; wr0 = wr_cnt;

      @(negedge clk);
      req_valid = 1'b1; req_lin = lin; req_write = wr; req_user = usr;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R10 ready low after accept", {31'h0, req_ready}, 32'h0);
      n = 0; to = 0;
      while (!rsp_valid && !to) begin
         @(negedge clk);
         n++;
         if (n > 200) to = 1;
      end
      if (to) begin
         chk(1'b0, "R10 watchdog no response", 32'h0, 32'h1);
         return;
      end
      chk(rsp_fault == e_flt, "R5/R6 fault flag", {31'h0, rsp_fault}, {31'h0, e_flt});
      if (e_flt) begin
         chk(rsp_status == {usr, wr, e_prot}, "R9 fault status", {29'h0, rsp_status}, {29'h0, usr, wr, e_prot});
         chk(rsp_status[0] == e_prot, e_prot ? "R6 protection cause" : "R5 not-present cause",
             {31'h0, rsp_status[0]}, {31'h0, e_prot});
         chk(rsp_paddr == 32'h0, "R9 paddr zero on fault", rsp_paddr, 32'h0);
      end else begin
         chk(rsp_status == 3'b000, "R9 clear status", {29'h0, rsp_status}, 32'h0);
         chk(rsp_paddr == e_pa, big ? "R4 large paddr" : "R3 small paddr", rsp_paddr, e_pa);
      end
      chk(fault_addr == cr2_model, e_flt ? "R5 fault_addr latched" : "R11 fault_addr kept",
          fault_addr, cr2_model);
      @(negedge clk);
      chk(!rsp_valid && req_ready, "R10 single pulse then idle", {30'h0, rsp_valid, req_ready}, 32'h1);
      chk(rd_cnt - rd0 == e_rd, big ? "R4 no table read" : "R2 read count",
          32'(rd_cnt - rd0), 32'(e_rd));
      chk(wr_cnt - wr0 == e_wr, "R7 write-back count", 32'(wr_cnt - wr0), 32'(e_wr));
      if (e_rd == 2) begin
         chk(hist1 == daddr, "R1 directory address", hist1, daddr);
         chk(hist0 == taddr, "R2 table address", hist0, taddr);
         chk(mem[taddr[13:2]] == pte_new, "R8 table entry flags", mem[taddr[13:2]], pte_new);
      end else begin
         chk(hist0 == daddr, "R1 directory address", hist0, daddr);
      end
      chk(mem[daddr[13:2]] == pde_new, "R7 directory entry flags", mem[daddr[13:2]], pde_new);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_req, "R10 reset state",
          {29'h0, req_ready, rsp_valid, mem_req}, 32'h4);
      chk(fault_addr == 32'h0, "R11 reset fault_addr", fault_addr, 32'h0);

      for (int i = 0; i < 4096; i++) load(12'(i), rnd_entry(i < 1024));

      // R8: large leaf, A and D clear, user write gets both in one write
      load(12'd5, 32'h8040_0087);
      walk({10'd5, 22'h12345}, 1'b1, 1'b1);
      // R8: table path, directory gains only Accessed; leaf gains both
      load(12'd6, 32'h0000_1007);
      load(12'd1024 + 12'd7, 32'hABCD_E007);
      walk({10'd6, 10'd7, 12'h9A4}, 1'b1, 1'b0);
      // R7: all flags already set, read: no writes
      walk({10'd6, 10'd7, 12'h010}, 1'b0, 1'b1);
      // R5: directory not present
      load(12'd8, 32'h0000_2006);
      walk({10'd8, 22'h0}, 1'b0, 1'b0);
      // R6: write to read-only table entry
      load(12'd1024 + 12'd9, 32'h1234_5005);
      walk({10'd6, 10'd9, 12'h0FF}, 1'b1, 1'b0);
      // R6: user access to supervisor directory entry
      load(12'd10, 32'h0000_3003);
      walk({10'd10, 22'h3}, 1'b0, 1'b1);

      for (int k = 0; k < 400; k++) begin
         logic [31:0] r;
         r = $urandom;
         walk(r, r[3], r[17]);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R10 global watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule